// File: doc/BRIEF.md
# Write-Triggered Transfer Event Detector

This block turns ordinary register-bus writes into DMA start events. It holds one mapping register per quick-transfer channel. Each mapping register names one of the parameter sets in a parameter memory window. It also names one of the eight 32-bit words inside that set. That word is the channel's trigger word.

The block snoops the bus port that leads into the parameter memory. When a write lands on a channel's trigger word, the block emits a one-cycle event for that channel on the next clock. The event carries a per-channel pulse vector, the lowest matching channel number and the set index of the write. A higher-level transfer controller consumes that event.

Software programs the mapping registers through a small word-indexed configuration port, and reads them back through the same port. The parameter storage and the transfer engine sit outside this block.

Top module: `qtrig_event_unit`

## Requirements
- R1: After reset, every mapping register reads back as zero, meaning set 0 and word 0. No event output is active. A write to byte address 0x4000 then raises an event on every channel.
- R2: A mapping register stores the set entry in bits 13:5 and the trigger-word index in bits 4:2. All other bits ignore writes and read back as zero.
- R3: A bus write to byte address A matches a channel when A lies in 0x4000–0x5FFF, (A-0x4000)/32 equals the channel's set entry and (A mod 32)/4 equals its trigger index. A match raises that channel's bit in `evtPulse` on the clock edge after the write is presented.
- R4: A write to any other word of the mapped set, or to any other set, raises no event for that channel.
- R5: A read access (`parWrite`=0) never raises an event, whatever its address.
- R6: Accesses outside the 0x4000–0x5FFF window never raise an event, even when address bits 13:2 match a mapping.
- R7: When several channels match one write, all of their pulse bits rise in the same cycle. `evtChan` gives the lowest matching channel number, and `evtSet` gives A[12:5] of the write.
- R8: A mapping write takes effect from the next cycle on. A parameter write presented in the same cycle is compared against the old mapping.
- R9: `evtValid` is high exactly when some pulse bit is high. Each matching write produces a pulse that lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Mapping register write strobe |
| cfgAddr | input | 3 | Mapping register word index (channel number) |
| cfgWrData | input | 32 | Mapping register write data |
| cfgRdData | output | 32 | Read data of the mapping register selected by cfgAddr (combinational) |
| parValid | input | 1 | Parameter bus access valid this cycle |
| parWrite | input | 1 | 1 = write, 0 = read |
| parAddr | input | 16 | Parameter bus byte address |
| evtPulse | output | 8 | Per-channel event pulse vector |
| evtValid | output | 1 | Any event this cycle |
| evtChan | output | 3 | Lowest channel with an event |
| evtSet | output | 8 | Parameter set index of the triggering write |

## Verification
Some properties are checked by assertions on every cycle. One is that a pulse only follows a decoded bus write, and that reads never produce a decoded write. Others are that at most one mapping register is written at a time, and that `evtChan` always points at the lowest set pulse bit. The assertions also check that the valid flag agrees with the pulse vector and that reserved read-back bits stay zero. Other behaviour is shown only by the bench's sweeps. Those sweeps cover the exact address arithmetic over all 2048 word slots, the silence of reads and of out-of-window aliases, the reset mapping to set 0, and the rule that a mapping change in the same cycle as a parameter write uses the old mapping.

// File: rtl/qtrig_pkg.sv
package qtrig_pkg;
  localparam int ENTRY_W   = 9;   // parameter-set entry field width
  localparam int ENTRY_LSB = 5;
  localparam int TRIG_W    = 3;   // trigger-word index width
  localparam int TRIG_LSB  = 2;
  localparam int SET_W     = 8;   // reported set index width
  localparam int DATA_W    = 32;

  // Strobe bundle from the bus decoder to the datapath
  typedef struct packed {
    logic               hit;    // write inside the parameter window
    logic [ENTRY_W-1:0] entry;  // set entry addressed
    logic [TRIG_W-1:0]  word;   // word within set addressed
  } trig_strobe_t;
endpackage

// File: rtl/qtrig_ctrl.sv
module qtrig_ctrl
  import qtrig_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CFG_AW   = 3,
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h4000,
  parameter int WIN_LSB  = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic               parValid,
  input  logic               parWrite,
  input  logic [ADDR_W-1:0]  parAddr,
  output logic [NUM_CH-1:0]  mapWe,
  output trig_strobe_t       stb
);
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(WIN_BASE);
  localparam int TAG_W = ADDR_W - WIN_LSB;

  logic inWindow;
  logic unusedLaneBits;

  assign inWindow = (parAddr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign unusedLaneBits = ^parAddr[TRIG_LSB-1:0];

  assign stb.hit   = parValid && parWrite && inWindow;
  assign stb.entry = parAddr[ENTRY_LSB+ENTRY_W-1:ENTRY_LSB];
  assign stb.word  = parAddr[TRIG_LSB+TRIG_W-1:TRIG_LSB];

  for (genvar g = 0; g < NUM_CH; g++) begin : gWe
    assign mapWe[g] = cfgWrEn && (cfgAddr == CFG_AW'(g));
  end

  AST_ONE_MAP_WE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mapWe)); // R2
  AST_READ_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (parValid && !parWrite) |-> !stb.hit); // R5
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !parValid |-> !stb.hit); // R3

  if (TAG_W < 1) begin : gBadWin
    initial $display("qtrig_ctrl: window tag width must be positive");
  end
endmodule

// File: rtl/qtrig_dpath.sv
module qtrig_dpath
  import qtrig_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CFG_AW = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  mapWe,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  trig_strobe_t       stb,
  output logic [DATA_W-1:0]  cfgRdData,
  output logic [NUM_CH-1:0]  evtPulse,
  output logic               evtValid,
  output logic [CFG_AW-1:0]  evtChan,
  output logic [SET_W-1:0]   evtSet
);
  localparam int PAD_W = DATA_W - ENTRY_LSB - ENTRY_W;

  logic [ENTRY_W-1:0] mapEntry [NUM_CH];
  logic [TRIG_W-1:0]  mapTrig  [NUM_CH];
  logic [NUM_CH-1:0]  hitVec;
  logic [CFG_AW-1:0]  firstIdx;
  logic               unusedResvBits;

  assign unusedResvBits = ^{cfgWrData[DATA_W-1:ENTRY_LSB+ENTRY_W], cfgWrData[TRIG_LSB-1:0]};

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mapEntry[g] <= '0;
        mapTrig[g]  <= '0;
      end else if (mapWe[g]) begin
        mapEntry[g] <= cfgWrData[ENTRY_LSB+ENTRY_W-1:ENTRY_LSB];
        mapTrig[g]  <= cfgWrData[TRIG_LSB+TRIG_W-1:TRIG_LSB];
      end
    end
    // compare against the mapping held before this edge
    assign hitVec[g] = stb.hit && (mapEntry[g] == stb.entry) && (mapTrig[g] == stb.word);
  end

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hitVec[i]) firstIdx = CFG_AW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPulse <= '0;
      evtValid <= 1'b0;
      evtChan  <= '0;
      evtSet   <= '0;
    end else begin
      evtPulse <= hitVec;
      evtValid <= |hitVec;
      evtChan  <= firstIdx;
      evtSet   <= stb.entry[SET_W-1:0];
    end
  end

  assign cfgRdData = {{PAD_W{1'b0}}, mapEntry[cfgAddr], mapTrig[cfgAddr], {TRIG_LSB{1'b0}}};

  AST_VALID_HAS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> evtPulse[evtChan]); // R7
  AST_CHAN_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> ((evtPulse & ((NUM_CH'(1) << evtChan) - NUM_CH'(1))) == '0)); // R7
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |-> (evtPulse == '0)); // R9
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |-> $past(stb.hit)); // R3
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[TRIG_LSB-1:0] == '0) && (cfgRdData[DATA_W-1:ENTRY_LSB+ENTRY_W] == '0)); // R2
endmodule

// File: rtl/qtrig_event_unit.sv
module qtrig_event_unit
  import qtrig_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h4000,
  parameter int WIN_LSB  = 13,
  localparam int CFG_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  output logic [DATA_W-1:0]  cfgRdData,
  input  logic               parValid,
  input  logic               parWrite,
  input  logic [ADDR_W-1:0]  parAddr,
  output logic [NUM_CH-1:0]  evtPulse,
  output logic               evtValid,
  output logic [CFG_AW-1:0]  evtChan,
  output logic [SET_W-1:0]   evtSet
);
  logic [NUM_CH-1:0] mapWe;
  trig_strobe_t      stb;

  qtrig_ctrl #(
    .NUM_CH(NUM_CH), .CFG_AW(CFG_AW), .ADDR_W(ADDR_W),
    .WIN_BASE(WIN_BASE), .WIN_LSB(WIN_LSB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .parValid(parValid), .parWrite(parWrite), .parAddr(parAddr),
    .mapWe(mapWe), .stb(stb)
  );

  qtrig_dpath #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) u_dpath (
    .clk(clk), .rstN(rstN),
    .mapWe(mapWe), .cfgWrData(cfgWrData), .cfgAddr(cfgAddr), .stb(stb),
    .cfgRdData(cfgRdData),
    .evtPulse(evtPulse), .evtValid(evtValid), .evtChan(evtChan), .evtSet(evtSet)
  );
endmodule

// File: tb/qtrig_event_unit_bench.sv
`timescale 1ns/1ps
module qtrig_event_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [2:0]  cfgAddr;
  logic [31:0] cfgWrData;
  logic [31:0] cfgRdData;
  logic        parValid, parWrite;
  logic [15:0] parAddr;
  logic [7:0]  evtPulse;
  logic        evtValid;
  logic [2:0]  evtChan;
  logic [7:0]  evtSet;

  int checks = 0;
  int fails  = 0;
  int mEntry [8];
  int mTrig  [8];

  always #5 clk = ~clk;

  qtrig_event_unit u_qtrig_event_unit (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .parValid(parValid), .parWrite(parWrite), .parAddr(parAddr),
    .evtPulse(evtPulse), .evtValid(evtValid), .evtChan(evtChan), .evtSet(evtSet)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expVec(int addr, bit wr);
    int v = 0;
    for (int c = 0; c < 8; c++) begin
      if (wr && addr >= 'h4000 && addr < 'h6000 &&
          (addr - 'h4000) / 32 == mEntry[c] && (addr % 32) / 4 == mTrig[c])
        v |= (1 << c);
    end
    return v;
  endfunction

  // check outputs one edge after an access with expected vector v
  task automatic chkEvt(string req, int addr, int v);
    int low = 0;
    chk({req, " pulse"}, int'(evtPulse), v);
    chk({req, " valid"}, int'(evtValid), (v != 0) ? 1 : 0);
    if (v != 0) begin
      for (int c = 7; c >= 0; c--) if (v[c]) low = c;
      chk({req, " chan"}, int'(evtChan), low);
      chk({req, " set"}, int'(evtSet), ((addr - 'h4000) / 32) % 256);
    end
  endtask

  task automatic cfgWrite(int ch, int entry, int trig, int junk);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 3'(ch);
    cfgWrData = 32'((entry << 5) | (trig << 2)) | 32'(junk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    mEntry[ch] = entry; mTrig[ch] = trig;
  endtask

  task automatic cfgCheck(string req, int ch);
    cfgAddr = 3'(ch);
    #1;
    chk(req, int'(cfgRdData), (mEntry[ch] << 5) | (mTrig[ch] << 2));
  endtask

  task automatic access(string req, int addr, bit wr);
    @(negedge clk);
    parValid = 1'b1; parWrite = wr; parAddr = 16'(addr);
    @(negedge clk);
    parValid = 1'b0;
    #1;
    chkEvt(req, addr, expVec(addr, wr));
  endtask

  task automatic runAll();
    rstN = 1'b0; cfgWrEn = 0; cfgAddr = 0; cfgWrData = 0;
    parValid = 0; parWrite = 0; parAddr = 0;
    for (int c = 0; c < 8; c++) begin mEntry[c] = 0; mTrig[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 pulse at reset", int'(evtPulse), 0);
    chk("R1 valid at reset", int'(evtValid), 0);
    for (int c = 0; c < 8; c++) cfgCheck("R1 mapping reset", c);
    access("R1 default set0 word0", 'h4000, 1'b1);
    chk("R1 all channels", int'(evtPulse), 'hFF);
    // R9: single-cycle pulse
    @(negedge clk); #1;
    chk("R9 pulse cleared", int'(evtPulse), 0);
    chk("R9 valid cleared", int'(evtValid), 0);

    // R2: distinct mappings with reserved bits set in the write data
    for (int c = 0; c < 8; c++) cfgWrite(c, (c * 37 + 3) % 256, (c * 3) % 8, 'hFFFF_C003);
    for (int c = 0; c < 8; c++) cfgCheck("R2 readback", c);

    // R3/R4: sweep every word of every set
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 8; w++)
        access("R3 R4 sweep", 'h4000 + s * 32 + w * 4, 1'b1);

    // R5: reads at every trigger address
    for (int c = 0; c < 8; c++)
      access("R5 read", 'h4000 + mEntry[c] * 32 + mTrig[c] * 4, 1'b0);

    // R6: aliases outside the window
    for (int c = 0; c < 8; c++) begin
      access("R6 above window", 'h6000 + mEntry[c] * 32 + mTrig[c] * 4, 1'b1);
      access("R6 below window", 'h2000 + mEntry[c] * 32 + mTrig[c] * 4, 1'b1);
      access("R6 low page", mEntry[c] * 32 + mTrig[c] * 4, 1'b1);
    end

    // R7: several channels on one trigger word
    cfgWrite(2, 77, 4, 0);
    cfgWrite(5, 77, 4, 0);
    cfgWrite(6, 77, 4, 0);
    access("R7 multi", 'h4000 + 77 * 32 + 16, 1'b1);
    chk("R7 multi vector", int'(evtPulse), 'h64);
    chk("R7 lowest chan", int'(evtChan), 2);
    access("R7 last set", 'h5FE0 + mTrig[0] * 4, 1'b1);

    // R8: same-cycle remap uses old mapping
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 3'd0; cfgWrData = (200 << 5) | (6 << 2);
    parValid = 1'b1; parWrite = 1'b1; parAddr = 16'('h4000 + mEntry[0] * 32 + mTrig[0] * 4);
    @(negedge clk);
    cfgWrEn = 1'b0; parValid = 1'b0;
    #1;
    chk("R8 old mapping used", int'(evtPulse[0]), 1);
    mEntry[0] = 200; mTrig[0] = 6;
    cfgCheck("R8 new mapping", 0);
    access("R8 old address now silent", 'h4000 + 3 * 32, 1'b1);
    chk("R8 old silent ch0", int'(evtPulse[0]), 0);
    access("R8 new address", 'h4000 + 200 * 32 + 24, 1'b1);
    chk("R8 new hit ch0", int'(evtPulse[0]), 1);
    @(negedge clk); #1;
    chk("R9 pulse one cycle", int'(evtPulse), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule